// File: doc/BRIEF.md
# Clock-Enable Serial Shifter

This block is a general-purpose transmit and receive shifter of one data word in each direction. Everything in it is clocked by the system clock. The moment at which a bit moves is set by a one-cycle shift enable. In master mode a reloadable down-counter supplies that enable. In slave mode it comes from the chosen edge of an external clock pin, after that pin has been synchronized and edge-detected. The external rate must therefore stay well below the system clock.

Software writes a whole transmit frame, start and stop bits included, into the transmit register. Bits leave from bit 0. A one enters at the top for each bit sent, so the line returns to its idle high level once the frame is out. For an 8-data-bit, 1-stop-bit character the frame word is `(c << 1) | 32'hFFFF_FE00`. The receiver shifts sampled line bits in at the top. After a programmed number of bits it copies the frame, right-justified, into a receive buffer and raises a data-available flag. Both shift registers can be read and written at any time.

An optional framed receive mode holds the receiver while the line is idle high. Reception begins with the first low (start) bit.

Top module: `sshift_top`

## Requirements
- R1: After reset, serOut is 1, txShiftOut is all ones, rxShiftOut and rxBuf are zero, and rxAvail is 0.
- R2: The transmitter sends LSB first. After k shift enables following a write of word w, serOut equals w[k] for k < 32 and equals 1 from then on, because a one enters bit 31 on every shift.
- R3: In master mode (cfgMaster=1), shift enables occur every cfgDivReload+1 system clock cycles.
- R4: In slave mode (cfgMaster=0), exactly one shift happens per selected edge of extClk. The selected edge is the rising edge when cfgFallEdge=0 and the falling edge when cfgFallEdge=1. The other edge moves nothing.
- R5: The receiver shifts the sampled line in at bit 31. After cfgFrameLen bits (legal values 1 to 32), rxBuf holds those bits right-justified with the first received bit at bit 0, and rxAvail becomes 1.
- R6: A one-cycle pulse on rxRead clears rxAvail on the next clock edge.
- R7: With txEnable=0 the transmit register does not shift. With rxEnable=0 the receive register does not shift.
- R8: txWrite and rxWrite load their register on the next edge and take priority over a shift in the same cycle. The loaded value is visible on txShiftOut or rxShiftOut.
- R9: With cfgFramed=1, shift enables that find the line high while no frame is in progress are ignored. The first low bit is bit 0 of the frame.
- R10: Clearing rxEnable discards a partly received frame. The next frame counts its bits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMaster | input | 1 | 1: divider enable, 0: external clock edge |
| cfgFallEdge | input | 1 | Slave mode: 1 shifts on the falling edge of extClk |
| cfgFramed | input | 1 | Receiver waits for a low start bit |
| cfgDivReload | input | 16 | Divider reload; the enable period is reload+1 cycles |
| cfgFrameLen | input | 6 | Receive frame length in bits, 1 to 32 |
| txEnable | input | 1 | Transmit shifting enable |
| rxEnable | input | 1 | Receive shifting enable; low clears the bit count |
| txWrite | input | 1 | Load the transmit register |
| txWriteData | input | 32 | Transmit frame word |
| txShiftOut | output | 32 | Current transmit register |
| rxWrite | input | 1 | Load the receive register |
| rxWriteData | input | 32 | Receive register load value |
| rxShiftOut | output | 32 | Current receive register |
| rxRead | input | 1 | Read strobe that clears rxAvail |
| rxBuf | output | 32 | Last completed frame, right-justified |
| rxAvail | output | 1 | A completed frame is waiting |
| extClk | input | 1 | External shift clock (slave mode) |
| serIn | input | 1 | Serial line input |
| serOut | output | 1 | Serial line output |

## Verification
In slave mode the receiver is swept over every frame length from 1 to 32, alternating between rising and falling shift edges. Each bit of an arbitrary word is checked, which separates bit-order and justification faults from length-count faults. Alongside, the transmitter is checked bit by bit to tell backfill errors from shift-order errors. In master mode an alternating pattern measures the enable period for several reload values, and a loopback of serOut into serIn checks frames of several lengths. Further runs cover a line held idle high in framed mode, an aborted partial frame, disabled directions and software loads, each showing whether ignored stimulus leaks into the registers.

// File: rtl/sshift_pkg.sv
package sshift_pkg;
  typedef struct packed {
    logic shiftTx;
    logic shiftRx;
    logic frameDone;
  } shStrobe_t;
endpackage

// File: rtl/sshift_ctrl.sv
module sshift_ctrl
  import sshift_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgFallEdge,
  input  logic             cfgFramed,
  input  logic [DIV_W-1:0] cfgDivReload,
  input  logic [CNT_W-1:0] cfgFrameLen,
  input  logic             txEnable,
  input  logic             rxEnable,
  input  logic             extClk,
  input  logic             serIn,
  output logic             serInSync,
  output shStrobe_t        strobe
);
  logic [2:0]       clkSync;
  logic [1:0]       dinSync;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] rxCnt;
  logic             rxBusy;
  logic             divZero, extRise, extFall, tick, rxGo, lastBit;

  // two-flop synchronizers; clock and data take the same latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0;
      dinSync <= '1;
    end else begin
      clkSync <= {clkSync[1:0], extClk};
      dinSync <= {dinSync[0], serIn};
    end
  end

  assign serInSync = dinSync[1];
  assign extRise   = clkSync[1] & ~clkSync[2];
  assign extFall   = ~clkSync[1] & clkSync[2];

  // reloadable divider, terminal count is the enable
  assign divZero = (divCnt == '0);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          divCnt <= '0;
    else if (!cfgMaster) divCnt <= '0;
    else if (divZero)   divCnt <= cfgDivReload;
    else                divCnt <= divCnt - 1'b1;
  end

  assign tick = cfgMaster ? divZero : (cfgFallEdge ? extFall : extRise);

  // receive frame counting
  assign rxGo    = rxEnable & tick & (rxBusy | ~cfgFramed | ~serInSync);
  assign lastBit = (rxCnt + 1'b1) == cfgFrameLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt  <= '0;
      rxBusy <= 1'b0;
    end else if (!rxEnable) begin
      rxCnt  <= '0;
      rxBusy <= 1'b0;
    end else if (rxGo) begin
      if (lastBit) begin
        rxCnt  <= '0;
        rxBusy <= 1'b0;
      end else begin
        rxCnt  <= rxCnt + 1'b1;
        rxBusy <= 1'b1;
      end
    end
  end

  always_comb begin
    strobe.shiftTx   = tick & txEnable;
    strobe.shiftRx   = rxGo;
    strobe.frameDone = rxGo & lastBit;
  end

  // R3: a nonzero reload keeps enables at least two cycles apart
  p_div_gap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && tick && cfgDivReload != '0) |=> (!tick || !cfgMaster));

  // R4: one edge yields a single one-cycle enable
  p_edge_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cfgMaster) |=> (!tick || cfgMaster || !$stable(cfgFallEdge)));

  // R5: the bit count stays inside the programmed frame
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rxCnt < cfgFrameLen) |=> (!$stable(cfgFrameLen) || rxCnt < cfgFrameLen));
endmodule

// File: rtl/sshift_dpath.sv
module sshift_dpath
  import sshift_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  shStrobe_t         strobe,
  input  logic [CNT_W-1:0]  cfgFrameLen,
  input  logic              serInSync,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txWriteData,
  input  logic              rxWrite,
  input  logic [WORD_W-1:0] rxWriteData,
  input  logic              rxRead,
  output logic [WORD_W-1:0] txReg,
  output logic [WORD_W-1:0] rxReg,
  output logic [WORD_W-1:0] rxBuf,
  output logic              rxAvail,
  output logic              serOut
);
  localparam logic [CNT_W-1:0] WORD_CNT = CNT_W'(WORD_W);

  logic [WORD_W-1:0] rxNext;

  assign rxNext = {serInSync, rxReg[WORD_W-1:1]};
  assign serOut = txReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               txReg <= '1;
    else if (txWrite)        txReg <= txWriteData;
    else if (strobe.shiftTx) txReg <= {1'b1, txReg[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rxReg <= '0;
    else if (rxWrite)        rxReg <= rxWriteData;
    else if (strobe.shiftRx) rxReg <= rxNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf   <= '0;
      rxAvail <= 1'b0;
    end else if (strobe.frameDone) begin
      rxBuf   <= rxNext >> (WORD_CNT - cfgFrameLen);
      rxAvail <= 1'b1;
    end else if (rxRead) begin
      rxAvail <= 1'b0;
    end
  end

  // R2: every transmit shift backfills an idle-high one
  p_backfill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftTx && !txWrite) |=> txReg[WORD_W-1]);

  // R5: a completed frame raises the flag
  p_avail_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameDone |=> rxAvail);

  // R6: a read without a new frame drops the flag
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxRead && !strobe.frameDone) |=> !rxAvail);
endmodule

// File: rtl/sshift_top.sv
module sshift_top
  import sshift_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  parameter int CNT_W  = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMaster,
  input  logic              cfgFallEdge,
  input  logic              cfgFramed,
  input  logic [DIV_W-1:0]  cfgDivReload,
  input  logic [CNT_W-1:0]  cfgFrameLen,
  input  logic              txEnable,
  input  logic              rxEnable,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txWriteData,
  output logic [WORD_W-1:0] txShiftOut,
  input  logic              rxWrite,
  input  logic [WORD_W-1:0] rxWriteData,
  output logic [WORD_W-1:0] rxShiftOut,
  input  logic              rxRead,
  output logic [WORD_W-1:0] rxBuf,
  output logic              rxAvail,
  input  logic              extClk,
  input  logic              serIn,
  output logic              serOut
);
  shStrobe_t strobe;
  logic      serInSync;

  sshift_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk, .rstN, .cfgMaster, .cfgFallEdge, .cfgFramed, .cfgDivReload,
    .cfgFrameLen, .txEnable, .rxEnable, .extClk, .serIn,
    .serInSync, .strobe
  );

  sshift_dpath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dpath (
    .clk, .rstN, .strobe, .cfgFrameLen, .serInSync,
    .txWrite, .txWriteData, .rxWrite, .rxWriteData, .rxRead,
    .txReg(txShiftOut), .rxReg(rxShiftOut), .rxBuf, .rxAvail, .serOut
  );

  // R7: disabled directions hold their registers
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !txWrite) |=> $stable(txShiftOut));
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rxEnable && !rxWrite) |=> $stable(rxShiftOut));

  // R8: software loads land on the next edge
  p_tx_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    txWrite |=> (txShiftOut == $past(txWriteData)));
  p_rx_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxWrite |=> (rxShiftOut == $past(rxWriteData)));
endmodule

// File: tb/sim_sshift_top.sv
`timescale 1ns/1ps
module sim_sshift_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgMaster = 0, cfgFallEdge = 0, cfgFramed = 0;
  logic [15:0] cfgDivReload = '0;
  logic [5:0]  cfgFrameLen = 6'd8;
  logic        txEnable = 0, rxEnable = 0;
  logic        txWrite = 0, rxWrite = 0, rxRead = 0;
  logic [31:0] txWriteData = '0, rxWriteData = '0;
  logic        extClk = 0, serInDrv = 1, loopBack = 0;
  logic [31:0] txShiftOut, rxShiftOut, rxBuf;
  logic        rxAvail, serOut, serIn;
  int          checks = 0, errors = 0;

  assign serIn = loopBack ? serOut : serInDrv;

  always #4 clk = ~clk;

  sshift_top u0 (
    .clk, .rstN, .cfgMaster, .cfgFallEdge, .cfgFramed, .cfgDivReload,
    .cfgFrameLen, .txEnable, .rxEnable, .txWrite, .txWriteData, .txShiftOut,
    .rxWrite, .rxWriteData, .rxShiftOut, .rxRead, .rxBuf, .rxAvail,
    .extClk, .serIn, .serOut
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one selected edge of the external clock, data held around it
  task automatic slaveBit(input logic b);
    serInDrv = b;
    extClk = cfgFallEdge;
    cyc(4);
    extClk = ~cfgFallEdge;
    cyc(4);
  endtask

  task automatic writeTx(input logic [31:0] w);
    txWrite = 1; txWriteData = w; cyc(1); txWrite = 0;
  endtask

  task automatic doRead;
    rxRead = 1; cyc(1); rxRead = 0;
  endtask

  function automatic logic [31:0] lowMask(input int n);
    return 32'((64'd1 << n) - 64'd1);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    check("R1 serOut", 32'(serOut), 32'd1);
    check("R1 txShiftOut", txShiftOut, 32'hFFFF_FFFF);
    check("R1 rxShiftOut", rxShiftOut, 32'd0);
    check("R1 rxBuf", rxBuf, 32'd0);
    check("R1 rxAvail", 32'(rxAvail), 32'd0);

    // R4 R5 R2: slave sweep over every frame length, both edges
    for (int n = 1; n <= 32; n++) begin
      logic [31:0] d, w;
      d = 32'hA5C3_96E1 ^ (32'(n) * 32'h0101_0307);
      w = ~d;
      cfgFallEdge = n[0];
      extClk = cfgFallEdge;
      cfgFrameLen = 6'(n);
      txEnable = 0; rxEnable = 0;
      cyc(4);
      writeTx(w);
      txEnable = 1; rxEnable = 1;
      for (int k = 0; k < n; k++) begin
        check("R2 tx bit", 32'(serOut), 32'(w[k]));
        slaveBit(d[k]);
        if (k < n - 1) check("R5 no early avail", 32'(rxAvail), 32'd0);
      end
      check("R5 rxAvail", 32'(rxAvail), 32'd1);
      check("R4 R5 rxBuf", rxBuf, d & lowMask(n));
      check("R2 tx after frame", 32'(serOut), (n < 32) ? 32'(w[n]) : 32'd1);
      doRead;
      check("R6 read clears", 32'(rxAvail), 32'd0);
    end
    // R2 backfill: several more shifts leave the line idle high
    rxEnable = 0;
    for (int k = 0; k < 3; k++) slaveBit(1'b0);
    check("R2 backfill", 32'(serOut), 32'd1);
    check("R2 backfill word", txShiftOut, 32'hFFFF_FFFF);

    // R2 8N1 frame built by software
    cfgFallEdge = 0; extClk = 0; txEnable = 0; cyc(4);
    begin
      logic [31:0] w8;
      logic [7:0] c;
      c = 8'h4D;
      w8 = (32'(c) << 1) | 32'hFFFF_FE00;
      writeTx(w8);
      txEnable = 1;
      for (int k = 0; k < 12; k++) begin
        check("R2 8N1 bit", 32'(serOut), (k == 0) ? 32'd0 : (k <= 8) ? 32'(c[k-1]) : 32'd1);
        slaveBit(1'b1);
      end
    end

    // R7 disabled directions
    txEnable = 0; rxEnable = 0;
    writeTx(32'h0000_0002);
    rxWrite = 1; rxWriteData = 32'h1234_5678; cyc(1); rxWrite = 0;
    check("R8 rx load", rxShiftOut, 32'h1234_5678);
    check("R8 tx load", txShiftOut, 32'h0000_0002);
    for (int k = 0; k < 3; k++) slaveBit(1'b1);
    check("R7 tx held", txShiftOut, 32'h0000_0002);
    check("R7 rx held", rxShiftOut, 32'h1234_5678);
    // R8: a load mid-frame replaces the shifting word
    txEnable = 1;
    slaveBit(1'b0);
    check("R8 shifted", 32'(serOut), 32'd1);
    writeTx(32'hFFFF_FFF0);
    check("R8 reload", 32'(serOut), 32'd0);

    // R10 aborted partial frame
    cfgFrameLen = 6'd4; rxEnable = 1;
    slaveBit(1'b1); slaveBit(1'b1);
    rxEnable = 0; cyc(2); rxEnable = 1;
    slaveBit(1'b0); slaveBit(1'b1); slaveBit(1'b1); slaveBit(1'b0);
    check("R10 avail", 32'(rxAvail), 32'd1);
    check("R10 realigned", rxBuf, 32'h6);
    doRead;

    // R9 framed receive ignores idle-high line
    cfgFramed = 1; cfgFrameLen = 6'd10; rxEnable = 0; cyc(2);
    rxWrite = 1; rxWriteData = 32'd0; cyc(1); rxWrite = 0;
    rxEnable = 1;
    for (int k = 0; k < 4; k++) slaveBit(1'b1);
    check("R9 idle ignored", rxShiftOut, 32'd0);
    check("R9 no avail", 32'(rxAvail), 32'd0);
    begin
      logic [7:0] c;
      c = 8'hB7;
      slaveBit(1'b0);
      for (int k = 0; k < 8; k++) slaveBit(c[k]);
      slaveBit(1'b1);
      check("R9 avail", 32'(rxAvail), 32'd1);
      check("R9 framed word", rxBuf, 32'h200 | (32'(c) << 1));
    end
    doRead;
    cfgFramed = 0; rxEnable = 0;

    // R3 master divider period, alternating pattern
    cfgMaster = 1;
    for (int r = 0; r <= 6; r++) begin
      txEnable = 0;
      cfgDivReload = 16'(r);
      writeTx(32'h5555_5555);
      txEnable = 1;
      begin
        logic prev;
        int cnt;
        prev = serOut;
        cnt = 0;
        while (serOut == prev && cnt < 50) begin cyc(1); cnt++; end
        for (int i = 0; i < 3; i++) begin
          prev = serOut;
          cnt = 0;
          while (serOut == prev && cnt < 50) begin cyc(1); cnt++; end
          check("R3 period", 32'(cnt), 32'(r + 1));
        end
      end
    end

    // R5 master loopback frames
    txEnable = 0; rxEnable = 0; loopBack = 1; cfgDivReload = 16'd3;
    for (int j = 0; j < 3; j++) begin
      logic [31:0] w;
      int n;
      n = (j == 0) ? 7 : (j == 1) ? 16 : 32;
      w = 32'hC0DE_1A5B ^ (32'(j) * 32'h3131_7777);
      cfgFrameLen = 6'(n);
      writeTx(w);
      cyc(3);
      txEnable = 1; rxEnable = 1;
      begin
        int cnt;
        cnt = 0;
        while (!rxAvail && cnt < 400) begin cyc(1); cnt++; end
      end
      txEnable = 0; rxEnable = 0;
      check("R5 loopback avail", 32'(rxAvail), 32'd1);
      check("R5 loopback word", rxBuf, w & lowMask(n));
      doRead;
      check("R6 clear after loopback", 32'(rxAvail), 32'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule